// File: doc/BRIEF.md
# Core Sleep and Wake Controller

This block decides when a small processor core stops and restarts. The pipeline hands it single-cycle pulses for a decoded wait-for-interrupt, a block hint and an unblock hint, with the current privilege level and the timeout-wait control bit. The controller then stalls the pipeline, and can also turn off the core clock enable or run a four-phase request/acknowledge exchange with an outside power controller. How deep the core sleeps is set by a depth value that is sampled when sleep begins. The block and unblock hints let cores in a cluster park and wake one another. An unblock hint sends a one-cycle pulse to the neighbouring cores. Unblock pulses from neighbours or other platform sources are held in a pending flag. A block hint that finds this flag set returns at once without sleeping.

The state machine has five states. S_RUN means the core is running. S_NAP is a shallow sleep, either stall only or stall with the clock gated. S_REQ holds the power request high while it waits for the acknowledge. S_OFF means power is down and the clock is gated. S_REL has dropped the request and waits for the acknowledge to fall. The transitions are entry (S_RUN to S_NAP, or S_RUN to S_REQ), nap wake (S_NAP to S_RUN), grant (S_REQ to S_OFF), deep wake (S_OFF to S_REL) and release done (S_REL to S_RUN).

Top module: `core_doze_ctrl`

## Requirements
- R1: After reset, stall_o=0, clk_en_o=1, pwr_req_o=0, illegal_o=0 and unblock_out_o=0.
- R2: With depth 2'b00, a WFI pulse raises stall_o from the next cycle while clk_en_o stays 1. stall_o falls in the cycle after an interrupt is seen.
- R3: With depth 2'b01, the core sleeps as in R2 and clk_en_o is 0 for the whole sleep. clk_en_o is never 0 while stall_o is 0.
- R4: With depth 2'b10 or 2'b11, the power exchange runs in this order. pwr_req_o rises with stall_o. clk_en_o drops only after pwr_ack_i is high. On wake, clk_en_o returns to 1 in the same cycle that pwr_req_o falls. stall_o is released only in the cycle after pwr_ack_i is seen low. pwr_req_o never falls while the acknowledge is low and never rises while it is high.
- R5: A legal block hint with nothing pending enters sleep at the selected depth. It is woken by an interrupt, a debug halt, or an unblock pulse arriving on any bit of unblock_in_i.
- R6: A legal block hint that finds the pending flag set does not sleep and clears the flag, so the next block hint sleeps.
- R7: An unblock pulse in the same cycle as a block hint counts as already received.
- R8: When tw_i=1 and priv_m_i=0, a block or unblock hint drives illegal_o high in the same cycle and has no effect. The core does not sleep, sends no pulse, and leaves the pending flag as it was. The hints are legal in machine mode or when tw_i=0.
- R9: A legal unblock hint gives a one-cycle unblock_out_o pulse in the following cycle.
- R10: Unblock pulses do not wake a WFI sleep, but they are latched as pending.
- R11: dbg_halt_i wakes the core from every sleep depth by the same path as an interrupt.
- R12: A WFI or block hint seen while an interrupt or debug halt is already asserted does not enter sleep.
- R13: The depth is sampled when sleep is entered. Changing depth_i during a sleep has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock (not gated) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Decoded WFI pulse |
| block_i | input | 1 | Decoded block hint pulse |
| unblock_i | input | 1 | Decoded unblock hint pulse |
| priv_m_i | input | 1 | 1 when executing in machine mode |
| tw_i | input | 1 | Timeout-wait control bit |
| depth_i | input | 2 | Sleep depth: 00 stall, 01 clock gate, 1x power exchange |
| irq_i | input | 1 | Interrupt that would end a WFI |
| dbg_halt_i | input | 1 | Debug halt request |
| unblock_in_i | input | N_SRC | Unblock pulses from neighbours and platform sources |
| pwr_ack_i | input | 1 | Power controller acknowledge |
| stall_o | output | 1 | Pipeline stall |
| clk_en_o | output | 1 | Core clock enable |
| pwr_req_o | output | 1 | Power-down request |
| illegal_o | output | 1 | Illegal instruction for the current hint |
| unblock_out_o | output | 1 | Unblock pulse to neighbouring cores |

## Verification
The embedded properties check on every cycle that the four-phase request is never dropped or raised out of turn. They also check that the clock is gated only while the pipeline is stalled, that the power is gated only while the acknowledge is held, that a block hint with something pending never stalls, and that an illegal hint sends no pulse. The directed scenarios are needed for the rest. These are the timing of each depth, which wake sources apply to WFI sleep and which to block sleep, how the pending flag is cleared across consecutive block hints, the same-cycle race, and whether depth is held during sleep.

// File: rtl/doze_pkg.sv
package doze_pkg;
    typedef enum logic [1:0] {
        DEPTH_STALL = 2'b00,
        DEPTH_GATE  = 2'b01,
        DEPTH_PWR   = 2'b10,
        DEPTH_PWR2  = 2'b11
    } depth_e;

    typedef enum logic [2:0] {
        S_RUN = 3'd0,
        S_NAP = 3'd1,
        S_REQ = 3'd2,
        S_OFF = 3'd3,
        S_REL = 3'd4
    } doze_state_e;
endpackage

// File: rtl/doze_hint_check.sv
module doze_hint_check (
    input  logic clk,
    input  logic rst_n,
    input  logic block_i,
    input  logic unblock_i,
    input  logic priv_m_i,
    input  logic tw_i,
    output logic blk_ok_o,
    output logic ublk_ok_o,
    output logic illegal_o,
    output logic post_o
);
    logic allowed;
    logic post_q;

    // Hints are trapped only below machine mode with timeout-wait set.
    always_comb begin
        allowed   = priv_m_i | ~tw_i;
        blk_ok_o  = block_i & allowed;
        ublk_ok_o = unblock_i & allowed;
        illegal_o = (block_i | unblock_i) & ~allowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) post_q <= 1'b0;
        else        post_q <= ublk_ok_o;
    end

    assign post_o = post_q;

    // R9: a legal unblock hint is followed by one posted pulse
    a_r9_post_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (unblock_i && (priv_m_i || !tw_i)) |=> post_o);
endmodule

// File: rtl/doze_unblock_latch.sv
module doze_unblock_latch #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             clear_i,
    output logic             arrive_o,
    output logic             pend_o
);
    logic pend_q;

    assign arrive_o = |src_i;

    // Clearing wins: an arrival in the same cycle is consumed by the clearer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (clear_i) pend_q <= 1'b0;
        else if (arrive_o) pend_q <= 1'b1;
    end

    assign pend_o = pend_q;

    // R10: an arrival that nobody consumes is remembered
    a_r10_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_o && !clear_i) |=> pend_o);
endmodule

// File: rtl/doze_fsm.sv
module doze_fsm
    import doze_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_i,
    input  logic       enter_blk_i,
    input  logic [1:0] depth_i,
    input  logic       irq_i,
    input  logic       dbg_i,
    input  logic       blk_wake_i,
    input  logic       ack_i,
    output logic       stall_o,
    output logic       clk_en_o,
    output logic       req_o,
    output logic       consume_o
);
    doze_state_e state_q, state_d;
    logic [1:0]  depth_q;
    logic        mode_blk_q;
    logic        wake;
    logic        deep;

    assign deep = depth_i[1];
    assign wake = irq_i | dbg_i | (mode_blk_q & blk_wake_i);

    // State register and entry-time captures.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_RUN;
            depth_q    <= DEPTH_STALL;
            mode_blk_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_RUN && enter_i) begin
                depth_q    <= depth_i;
                mode_blk_q <= enter_blk_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN: if (enter_i) state_d = deep ? S_REQ : S_NAP;
            S_NAP: if (wake)    state_d = S_RUN;
            S_REQ: if (ack_i)   state_d = S_OFF;
            S_OFF: if (wake)    state_d = S_REL;
            S_REL: if (!ack_i)  state_d = S_RUN;
            default:            state_d = S_RUN;
        endcase
    end

    // Outputs.
    always_comb begin
        stall_o   = 1'b1;
        clk_en_o  = 1'b1;
        req_o     = 1'b0;
        consume_o = 1'b0;
        unique case (state_q)
            S_RUN: stall_o = 1'b0;
            S_NAP: begin
                clk_en_o  = (depth_q != DEPTH_GATE);
                consume_o = mode_blk_q & wake;
            end
            S_REQ: req_o = 1'b1;
            S_OFF: begin
                req_o     = 1'b1;
                clk_en_o  = 1'b0;
                consume_o = mode_blk_q & wake;
            end
            S_REL: ;
            default: stall_o = 1'b0;
        endcase
    end

    // R4: request held until acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
    // R4: no new request until acknowledge falls
    a_r4_no_rereq: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && ack_i) |=> !req_o);
    // R4: power-level gating only with acknowledge held
    a_r4_gate_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o && req_o) |-> ack_i);
    // R3: clock is gated only while stalled
    a_r3_gate_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |-> stall_o);
endmodule

// File: rtl/core_doze_ctrl.sv
module core_doze_ctrl #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_i,
    input  logic             block_i,
    input  logic             unblock_i,
    input  logic             priv_m_i,
    input  logic             tw_i,
    input  logic [1:0]       depth_i,
    input  logic             irq_i,
    input  logic             dbg_halt_i,
    input  logic [N_SRC-1:0] unblock_in_i,
    input  logic             pwr_ack_i,
    output logic             stall_o,
    output logic             clk_en_o,
    output logic             pwr_req_o,
    output logic             illegal_o,
    output logic             unblock_out_o
);
    logic blk_ok, ublk_ok;
    logic arrive, pend, consume;
    logic have_unblock, blk_sleep, enter;

    doze_hint_check u_hint (
        .clk       (clk),
        .rst_n     (rst_n),
        .block_i   (block_i),
        .unblock_i (unblock_i),
        .priv_m_i  (priv_m_i),
        .tw_i      (tw_i),
        .blk_ok_o  (blk_ok),
        .ublk_ok_o (ublk_ok),
        .illegal_o (illegal_o),
        .post_o    (unblock_out_o)
    );

    doze_unblock_latch #(.N_SRC(N_SRC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (unblock_in_i),
        .clear_i  (blk_ok | consume),
        .arrive_o (arrive),
        .pend_o   (pend)
    );

    // A block hint falls through when an unblock is pending or arriving now.
    assign have_unblock = pend | arrive;
    assign blk_sleep    = blk_ok & ~have_unblock;
    assign enter        = (wfi_i | blk_sleep) & ~(irq_i | dbg_halt_i);

    doze_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (enter),
        .enter_blk_i (blk_sleep),
        .depth_i     (depth_i),
        .irq_i       (irq_i),
        .dbg_i       (dbg_halt_i),
        .blk_wake_i  (have_unblock),
        .ack_i       (pwr_ack_i),
        .stall_o     (stall_o),
        .clk_en_o    (clk_en_o),
        .req_o       (pwr_req_o),
        .consume_o   (consume)
    );

    // R6/R7: block hint with an unblock in hand never sleeps
    a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && block_i && (priv_m_i || !tw_i) && (pend || (|unblock_in_i)))
        |=> !stall_o);
    // R8: a trapped hint posts nothing
    a_r8_no_post: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !unblock_out_o);
    // R12: no entry with a wake source already asserted
    a_r12_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && (irq_i || dbg_halt_i)) |=> !stall_o);
endmodule

// File: tb/core_doze_ctrl_bench.sv
module core_doze_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi_i = 0, block_i = 0, unblock_i = 0;
    logic       priv_m_i = 1, tw_i = 0;
    logic [1:0] depth_i = 2'b00;
    logic       irq_i = 0, dbg_halt_i = 0, pwr_ack_i = 0;
    logic [1:0] unblock_in_i = 2'b00;
    logic       stall_o, clk_en_o, pwr_req_o, illegal_o, unblock_out_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    core_doze_ctrl #(.N_SRC(2)) u_core_doze_ctrl (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi_i), .block_i(block_i),
        .unblock_i(unblock_i), .priv_m_i(priv_m_i), .tw_i(tw_i),
        .depth_i(depth_i), .irq_i(irq_i), .dbg_halt_i(dbg_halt_i),
        .unblock_in_i(unblock_in_i), .pwr_ack_i(pwr_ack_i),
        .stall_o(stall_o), .clk_en_o(clk_en_o), .pwr_req_o(pwr_req_o),
        .illegal_o(illegal_o), .unblock_out_o(unblock_out_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wake_irq();
        irq_i = 1; step(); irq_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 stall", stall_o, 0);
        chk("R1 clk_en", clk_en_o, 1);
        chk("R1 req", pwr_req_o, 0);
        chk("R1 illegal", illegal_o, 0);
        chk("R1 unblock_out", unblock_out_o, 0);
    endtask

    task automatic t_wfi_stall();
        depth_i = 2'b00; wfi_i = 1; step(); wfi_i = 0;
        chk("R2 stall on", stall_o, 1);
        chk("R2 clk_en kept", clk_en_o, 1);
        step(); step();
        chk("R2 stall held", stall_o, 1);
        wake_irq();
        chk("R2 stall off after irq", stall_o, 0);
    endtask

    task automatic t_wfi_gate();
        depth_i = 2'b01; wfi_i = 1; step(); wfi_i = 0;
        chk("R3 stall on", stall_o, 1);
        chk("R3 clk gated", clk_en_o, 0);
        depth_i = 2'b00; step();
        chk("R13 depth held", clk_en_o, 0);
        wake_irq();
        chk("R3 clk back", clk_en_o, 1);
        chk("R3 stall off", stall_o, 0);
    endtask

    task automatic t_power();
        depth_i = 2'b10; wfi_i = 1; step(); wfi_i = 0;
        chk("R4 req up", pwr_req_o, 1);
        chk("R4 stall up", stall_o, 1);
        chk("R4 clk before ack", clk_en_o, 1);
        step();
        chk("R4 req held w/o ack", pwr_req_o, 1);
        pwr_ack_i = 1; step();
        chk("R4 clk gated after ack", clk_en_o, 0);
        irq_i = 1; step(); irq_i = 0;
        chk("R4 req dropped", pwr_req_o, 0);
        chk("R4 clk released with req", clk_en_o, 1);
        chk("R4 stall until ack low", stall_o, 1);
        step();
        chk("R4 still waiting ack", stall_o, 1);
        pwr_ack_i = 0; step();
        chk("R4 stall released", stall_o, 0);
        depth_i = 2'b00;
    endtask

    task automatic t_block_sleep();
        block_i = 1; step(); block_i = 0;
        chk("R5 block sleeps", stall_o, 1);
        step();
        unblock_in_i = 2'b10; step(); unblock_in_i = 0;
        chk("R5 woken by unblock", stall_o, 0);
        block_i = 1; step(); block_i = 0;
        chk("R5 wake consumed, sleeps again", stall_o, 1);
        dbg_halt_i = 1; step(); dbg_halt_i = 0;
        chk("R11 debug wakes block", stall_o, 0);
    endtask

    task automatic t_pending();
        unblock_in_i = 2'b01; step(); unblock_in_i = 0; step();
        block_i = 1; step(); block_i = 0;
        chk("R6 falls through", stall_o, 0);
        block_i = 1; step(); block_i = 0;
        chk("R6 flag consumed", stall_o, 1);
        wake_irq();
        chk("R6 wake", stall_o, 0);
    endtask

    task automatic t_same_cycle();
        block_i = 1; unblock_in_i = 2'b01; step();
        block_i = 0; unblock_in_i = 0;
        chk("R7 same-cycle falls through", stall_o, 0);
        block_i = 1; step(); block_i = 0;
        chk("R7 consumed", stall_o, 1);
        wake_irq();
    endtask

    task automatic t_illegal();
        priv_m_i = 0; tw_i = 1;
        unblock_in_i = 2'b01; step(); unblock_in_i = 0;
        block_i = 1; #1;
        chk("R8 illegal block", illegal_o, 1);
        step(); block_i = 0;
        chk("R8 no sleep", stall_o, 0);
        unblock_i = 1; #1;
        chk("R8 illegal unblock", illegal_o, 1);
        step(); unblock_i = 0;
        chk("R8 no post", unblock_out_o, 0);
        wfi_i = 1; #1;
        chk("R8 wfi not trapped here", illegal_o, 0);
        wfi_i = 0;
        priv_m_i = 1; block_i = 1; #1;
        chk("R8 M-mode legal", illegal_o, 0);
        step(); block_i = 0;
        chk("R8 pending kept through trap", stall_o, 0);
        priv_m_i = 0; tw_i = 0; unblock_i = 1; #1;
        chk("R8 tw clear legal", illegal_o, 0);
        step(); unblock_i = 0;
        chk("R9 pulse", unblock_out_o, 1);
        step();
        chk("R9 pulse one cycle", unblock_out_o, 0);
        priv_m_i = 1;
    endtask

    task automatic t_wfi_ignores_unblock();
        wfi_i = 1; step(); wfi_i = 0;
        unblock_in_i = 2'b10; step(); unblock_in_i = 0;
        chk("R10 wfi not woken", stall_o, 1);
        wake_irq();
        block_i = 1; step(); block_i = 0;
        chk("R10 latched during wfi", stall_o, 0);
    endtask

    task automatic t_debug_deep();
        depth_i = 2'b11; wfi_i = 1; step(); wfi_i = 0;
        pwr_ack_i = 1; step();
        dbg_halt_i = 1; step(); dbg_halt_i = 0;
        chk("R11 debug drops req", pwr_req_o, 0);
        pwr_ack_i = 0; step();
        chk("R11 debug exit", stall_o, 0);
        depth_i = 2'b00;
    endtask

    task automatic t_entry_blocked();
        irq_i = 1; wfi_i = 1; step(); wfi_i = 0;
        chk("R12 wfi with irq", stall_o, 0);
        irq_i = 0; dbg_halt_i = 1; block_i = 1; step();
        block_i = 0; dbg_halt_i = 0;
        chk("R12 block with debug", stall_o, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        t_reset();
        t_wfi_stall();
        t_wfi_gate();
        t_power();
        t_block_sleep();
        t_pending();
        t_same_cycle();
        t_illegal();
        t_wfi_ignores_unblock();
        t_debug_deep();
        t_entry_blocked();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule